// File: doc/BRIEF.md
# Flash Status Register with Sticky Fault Flags

This block holds the status byte of a flash memory device and presents it on the device's read data bus. The embedded write controller reports its progress through a set of single-cycle event inputs: an operation starts, an operation completes, suspend is entered or left, and an erase or program attempt fails. The block turns these events into the ready, suspend and fault bits. The sector-protect state is taken live from an input pin. Software can read the byte after it writes the read-status command, and it can clear the fault bits only by writing the clear command.

Reads use two active-low strobes, the chip select and the output enable. The value that reaches the bus is captured on the clock in which the second of the two strobes goes low, and it is held until one of the strobes is released. A status poll that is in progress therefore never sees a value change under it. A word-mode input chooses between a 16-bit bus and an 8-bit bus. In array mode the block passes the array read data straight through.

Top module: `flash_status_reg`

## Requirements
- R1: After reset the stored bits are ready=1, suspend=0, erase-fail=0, program-fail=0. Both output enables are low and the block is in array-read mode.
- R2: A status read returns bit 7 ready, bit 6 suspend, bit 5 erase-fail, bit 4 program-fail, bit 3 sector-protect and bits 2..0 as 0.
- R3: `op_start` clears the ready bit and `op_done` sets it. When both are high in the same cycle, `op_start` wins.
- R4: `op_susp_set` sets the suspend bit and `op_susp_clr` clears it. When both are high, the set wins.
- R5: `op_efail` sets bit 5 and `op_pfail` sets bit 4. No controller event ever clears either bit.
- R6: A command write of 50h clears bits 5 and 4 and leaves every other bit alone. A fail event in the same cycle keeps its bit set.
- R7: Bit 3 follows `prot_in`. Neither the clear command nor any controller event changes it.
- R8: The bus value is captured in the clock in which the later of `ce_n` and `oe_n` is sampled low. It stays constant while both stay low, and a fresh value appears only after one strobe goes high and then low again.
- R9: In word mode a status read drives the upper byte as 00h and raises `bus_oe_hi`. In byte mode `bus_oe_hi` stays low.
- R10: Command 70h selects status mode and FFh selects array mode. `op_start` also selects status mode. Any other code, 50h included, leaves the mode unchanged. In array mode the bus carries `array_q`, or only its low byte in byte mode.
- R11: `bus_oe_lo` is high only in the cycle after both strobes are sampled low. `bus_oe_hi` is never high while `bus_oe_lo` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, covering power-up and wake from deep power-down |
| cmd_we | input | 1 | Command write strobe, one cycle |
| cmd_byte | input | 8 | Command code |
| op_start | input | 1 | Write controller starts an operation |
| op_done | input | 1 | Write controller finishes an operation |
| op_susp_set | input | 1 | Write controller enters suspend |
| op_susp_clr | input | 1 | Write controller leaves suspend |
| op_efail | input | 1 | Erase failure event |
| op_pfail | input | 1 | Program failure event |
| prot_in | input | 1 | Sector-protect state |
| word_mode | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| array_q | input | 16 | Array read data |
| bus_q | output | 16 | Read data presented to the bus |
| bus_oe_lo | output | 1 | Drive enable for the low byte |
| bus_oe_hi | output | 1 | Drive enable for the high byte |

## Verification
The hardest case to reach from the ports is a status change that lands while a read is already open, and a read whose second strobe falls after the status has moved. The bench lowers `oe_n` alone and fires a start event. Only then does it lower `ce_n`, and the captured value must show the busy state. With both strobes still held low it fires a done event and checks that the bus keeps the old value until `oe_n` is raised and lowered again. The bench also fires a clear command and a fail event in the same cycle, and it fires start and done in the same cycle, to check the priority rules.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
   localparam int FLG_RDY  = 3;
   localparam int FLG_SUSP = 2;
   localparam int FLG_EF   = 1;
   localparam int FLG_PF   = 0;
   localparam int FLG_W    = 4;
   localparam logic [FLG_W-1:0] FLG_RESET = 4'b1000;

   typedef enum logic {MODE_ARRAY = 1'b0, MODE_STATUS = 1'b1} mode_e;
endpackage

// File: rtl/fsr_flags.sv
module fsr_flags
   import fsr_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_start,
   input  logic             op_done,
   input  logic             op_susp_set,
   input  logic             op_susp_clr,
   input  logic             op_efail,
   input  logic             op_pfail,
   input  logic             host_clr,
   output logic [FLG_W-1:0] flags_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= FLG_RESET;
      end else begin
         if (op_start)      flags_q[FLG_RDY] <= 1'b0;
         else if (op_done)  flags_q[FLG_RDY] <= 1'b1;

         if (op_susp_set)      flags_q[FLG_SUSP] <= 1'b1;
         else if (op_susp_clr) flags_q[FLG_SUSP] <= 1'b0;

         if (op_efail)      flags_q[FLG_EF] <= 1'b1;
         else if (host_clr) flags_q[FLG_EF] <= 1'b0;

         if (op_pfail)      flags_q[FLG_PF] <= 1'b1;
         else if (host_clr) flags_q[FLG_PF] <= 1'b0;
      end
   end
endmodule

// File: rtl/fsr_cmd.sv
module fsr_cmd
   import fsr_pkg::*;
#(
   parameter int              CMD_W      = 8,
   parameter logic [CMD_W-1:0] CODE_STAT = 8'h70,
   parameter logic [CMD_W-1:0] CODE_CLR  = 8'h50,
   parameter logic [CMD_W-1:0] CODE_ARR  = 8'hFF
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_we,
   input  logic [CMD_W-1:0] cmd_byte,
   input  logic             op_start,
   output mode_e            mode_q,
   output logic             host_clr
);
   assign host_clr = cmd_we && (cmd_byte == CODE_CLR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_ARRAY;
      end else if (op_start) begin
         mode_q <= MODE_STATUS;
      end else if (cmd_we) begin
         if (cmd_byte == CODE_STAT)     mode_q <= MODE_STATUS;
         else if (cmd_byte == CODE_ARR) mode_q <= MODE_ARRAY;
      end
   end
endmodule

// File: rtl/fsr_capture.sv
module fsr_capture #(
   parameter int DATA_W       = 16,
   parameter bit WORD_SUPPORT = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              word_mode,
   input  logic              stat_mode,
   input  logic [7:0]        status_byte,
   input  logic [DATA_W-1:0] array_q,
   output logic [DATA_W-1:0] bus_q,
   output logic              bus_oe_lo,
   output logic              bus_oe_hi,
   output logic              snap_stat
);
   localparam int HALF = DATA_W / 2;

   logic              word_eff;
   logic              rd_act, act_q, word_q;
   logic [DATA_W-1:0] live, snap_q;

   generate
      if (WORD_SUPPORT) begin : g_word
         assign word_eff = word_mode;
      end else begin : g_byte_only
         logic unused_wm;
         assign unused_wm = word_mode;
         assign word_eff  = 1'b0;
      end
   endgenerate

   always_comb begin
      live = '0;
      if (stat_mode)      live[7:0] = status_byte;
      else if (word_eff)  live      = array_q;
      else                live[HALF-1:0] = array_q[HALF-1:0];
   end

   assign rd_act = !ce_n && !oe_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q     <= 1'b0;
         word_q    <= 1'b0;
         snap_stat <= 1'b0;
         snap_q    <= '0;
      end else begin
         act_q <= rd_act;
         if (rd_act && !act_q) begin
            snap_q    <= live;
            word_q    <= word_eff;
            snap_stat <= stat_mode;
         end
      end
   end

   assign bus_q     = snap_q;
   assign bus_oe_lo = act_q;
   assign bus_oe_hi = act_q && word_q;
endmodule

// File: rtl/flash_status_reg.sv
module flash_status_reg
   import fsr_pkg::*;
#(
   parameter int  DATA_W       = 16,
   parameter int  CMD_W        = 8,
   parameter bit  WORD_SUPPORT = 1'b1,
   parameter logic [CMD_W-1:0] CODE_STAT = 8'h70,
   parameter logic [CMD_W-1:0] CODE_CLR  = 8'h50,
   parameter logic [CMD_W-1:0] CODE_ARR  = 8'hFF
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_we,
   input  logic [CMD_W-1:0]  cmd_byte,
   input  logic              op_start,
   input  logic              op_done,
   input  logic              op_susp_set,
   input  logic              op_susp_clr,
   input  logic              op_efail,
   input  logic              op_pfail,
   input  logic              prot_in,
   input  logic              word_mode,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic [DATA_W-1:0] array_q,
   output logic [DATA_W-1:0] bus_q,
   output logic              bus_oe_lo,
   output logic              bus_oe_hi
);
   generate
      if (DATA_W != 16) begin : g_bad_width
         $error("flash_status_reg: DATA_W must be 16");
      end
      if (CMD_W < 8) begin : g_bad_cmd
         $error("flash_status_reg: CMD_W must be at least 8");
      end
   endgenerate

   logic [FLG_W-1:0] flags_q;
   logic             host_clr;
   logic             snap_stat;
   mode_e            mode_q;
   logic [7:0]       status_byte;

   fsr_cmd #(
      .CMD_W(CMD_W), .CODE_STAT(CODE_STAT), .CODE_CLR(CODE_CLR), .CODE_ARR(CODE_ARR)
   ) u_cmd (
      .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_byte(cmd_byte),
      .op_start(op_start), .mode_q(mode_q), .host_clr(host_clr)
   );

   fsr_flags u_flags (
      .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_done(op_done),
      .op_susp_set(op_susp_set), .op_susp_clr(op_susp_clr),
      .op_efail(op_efail), .op_pfail(op_pfail), .host_clr(host_clr),
      .flags_q(flags_q)
   );

   assign status_byte = {flags_q, prot_in, 3'b000};

   fsr_capture #(
      .DATA_W(DATA_W), .WORD_SUPPORT(WORD_SUPPORT)
   ) u_cap (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n),
      .word_mode(word_mode), .stat_mode(mode_q == MODE_STATUS),
      .status_byte(status_byte), .array_q(array_q),
      .bus_q(bus_q), .bus_oe_lo(bus_oe_lo), .bus_oe_hi(bus_oe_hi),
      .snap_stat(snap_stat)
   );
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker #(
   parameter int              DATA_W   = 16,
   parameter int              CMD_W    = 8,
   parameter logic [CMD_W-1:0] CODE_CLR = 8'h50
)(
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_we,
   input logic [CMD_W-1:0]  cmd_byte,
   input logic              op_start,
   input logic              op_done,
   input logic              op_efail,
   input logic              op_pfail,
   input logic [3:0]        flags_q,
   input logic              snap_stat,
   input logic [DATA_W-1:0] bus_q,
   input logic              bus_oe_lo,
   input logic              bus_oe_hi
);
   logic clr_w;
   assign clr_w = cmd_we && (cmd_byte == CODE_CLR);

   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      op_start |=> !flags_q[3]);                                          // R3
   AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (op_done && !op_start) |=> flags_q[3]);                             // R3
   AST_EFAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_q[1] && !clr_w) |=> flags_q[1]);                             // R5
   AST_PFAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_q[0] && !clr_w) |=> flags_q[0]);                             // R5
   AST_CLEAR_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_w && !op_efail && !op_pfail) |=> (flags_q[1:0] == 2'b00));     // R6
   AST_HOLD_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_oe_lo && $past(bus_oe_lo)) |-> $stable(bus_q));                // R8
   AST_UPPER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_oe_hi && snap_stat) |-> (bus_q[DATA_W-1:8] == '0));            // R9
   AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_oe_lo && snap_stat) |-> (bus_q[2:0] == 3'b000));               // R2
   AST_OE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe_hi |-> bus_oe_lo);                                           // R11
endmodule

bind flash_status_reg fsr_checker #(
   .DATA_W(DATA_W), .CMD_W(CMD_W), .CODE_CLR(CODE_CLR)
) u_fsr_checker (
   .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_byte(cmd_byte),
   .op_start(op_start), .op_done(op_done), .op_efail(op_efail), .op_pfail(op_pfail),
   .flags_q(flags_q), .snap_stat(snap_stat), .bus_q(bus_q),
   .bus_oe_lo(bus_oe_lo), .bus_oe_hi(bus_oe_hi)
);

// File: tb/flash_status_reg_test.sv
module flash_status_reg_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_we = 1'b0;
   logic [7:0]  cmd_byte = 8'h00;
   logic        op_start = 1'b0, op_done = 1'b0, op_susp_set = 1'b0, op_susp_clr = 1'b0;
   logic        op_efail = 1'b0, op_pfail = 1'b0;
   logic        prot_in = 1'b0, word_mode = 1'b1;
   logic        ce_n = 1'b1, oe_n = 1'b1;
   logic [15:0] array_q = 16'hA55A;
   logic [15:0] bus_q;
   logic        bus_oe_lo, bus_oe_hi;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_status_reg uut (
      .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_byte(cmd_byte),
      .op_start(op_start), .op_done(op_done), .op_susp_set(op_susp_set),
      .op_susp_clr(op_susp_clr), .op_efail(op_efail), .op_pfail(op_pfail),
      .prot_in(prot_in), .word_mode(word_mode), .ce_n(ce_n), .oe_n(oe_n),
      .array_q(array_q), .bus_q(bus_q), .bus_oe_lo(bus_oe_lo), .bus_oe_hi(bus_oe_hi)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cmd(input logic [7:0] b);
      cmd_we = 1'b1; cmd_byte = b;
      @(negedge clk);
      cmd_we = 1'b0;
   endtask

   task automatic op(input logic s, input logic d, input logic ss, input logic sc,
                     input logic ef, input logic pf);
      op_start = s; op_done = d; op_susp_set = ss; op_susp_clr = sc;
      op_efail = ef; op_pfail = pf;
      @(negedge clk);
      op_start = 0; op_done = 0; op_susp_set = 0; op_susp_clr = 0;
      op_efail = 0; op_pfail = 0;
   endtask

   task automatic rd(input string req, input logic [15:0] exp, input logic exp_hi);
      ce_n = 1'b0; oe_n = 1'b0;
      @(negedge clk);
      chk(req, bus_q, exp);
      chk({req, " oe_lo"}, {15'd0, bus_oe_lo}, 16'd1);
      chk({req, " oe_hi"}, {15'd0, bus_oe_hi}, {15'd0, exp_hi});
      ce_n = 1'b1; oe_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset;
      chk("R1 oe_lo after reset", {15'd0, bus_oe_lo}, 16'd0);
      chk("R1 oe_hi after reset", {15'd0, bus_oe_hi}, 16'd0);
      rd("R1 array mode after reset", 16'hA55A, 1'b1);
      cmd(8'h70);
      rd("R1 R2 reset status 80h", 16'h0080, 1'b1);
   endtask

   task automatic t_wsm;
      op(1, 0, 0, 0, 0, 0);
      rd("R3 busy after start", 16'h0000, 1'b1);
      op(0, 0, 0, 0, 0, 1);
      rd("R5 program fail set", 16'h0010, 1'b1);
      op(0, 1, 0, 0, 0, 0);
      rd("R3 ready after done", 16'h0090, 1'b1);
      op(1, 0, 0, 0, 0, 0);
      rd("R5 fail survives start", 16'h0010, 1'b1);
      op(0, 1, 0, 0, 1, 0);
      rd("R5 erase fail set", 16'h00B0, 1'b1);
      op(1, 1, 0, 0, 0, 0);
      rd("R3 start wins over done", 16'h0030, 1'b1);
      op(0, 1, 0, 0, 0, 0);
      rd("R5 fails survive done", 16'h00B0, 1'b1);
   endtask

   task automatic t_clear;
      cmd(8'h50);
      rd("R6 clear drops fails", 16'h0080, 1'b1);
      cmd_we = 1'b1; cmd_byte = 8'h50; op_efail = 1'b1;
      @(negedge clk);
      cmd_we = 1'b0; op_efail = 1'b0;
      rd("R6 set beats clear", 16'h00A0, 1'b1);
      cmd(8'h50);
      rd("R6 second clear", 16'h0080, 1'b1);
   endtask

   task automatic t_susp;
      op(0, 0, 1, 0, 0, 0);
      rd("R4 suspend set", 16'h00C0, 1'b1);
      cmd(8'h50);
      rd("R6 clear keeps suspend", 16'h00C0, 1'b1);
      op(0, 0, 1, 1, 0, 0);
      rd("R4 set wins over clear", 16'h00C0, 1'b1);
      op(0, 0, 0, 1, 0, 0);
      rd("R4 suspend cleared", 16'h0080, 1'b1);
   endtask

   task automatic t_prot;
      prot_in = 1'b1;
      @(negedge clk);
      rd("R7 protect shows", 16'h0088, 1'b1);
      cmd(8'h50);
      op(0, 1, 0, 0, 0, 0);
      rd("R7 protect unchanged", 16'h0088, 1'b1);
      prot_in = 1'b0;
      @(negedge clk);
      rd("R7 protect follows pin", 16'h0080, 1'b1);
   endtask

   task automatic t_snap;
      oe_n = 1'b0;
      @(negedge clk);
      chk("R11 one strobe no drive", {15'd0, bus_oe_lo}, 16'd0);
      op(1, 0, 0, 0, 0, 0);
      ce_n = 1'b0;
      @(negedge clk);
      chk("R8 later strobe captures new", bus_q, 16'h0000);
      op(0, 1, 0, 0, 0, 0);
      chk("R8 held while low", bus_q, 16'h0000);
      @(negedge clk);
      chk("R8 still held", bus_q, 16'h0000);
      oe_n = 1'b1;
      @(negedge clk);
      chk("R11 released", {15'd0, bus_oe_lo}, 16'd0);
      oe_n = 1'b0;
      @(negedge clk);
      chk("R8 retoggle shows new", bus_q, 16'h0080);
      ce_n = 1'b1; oe_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_byte;
      word_mode = 1'b0;
      rd("R9 byte mode status", 16'h0080, 1'b0);
      cmd(8'hFF);
      rd("R10 byte mode array", 16'h005A, 1'b0);
      word_mode = 1'b1;
   endtask

   task automatic t_mode;
      rd("R10 FF gives array", 16'hA55A, 1'b1);
      cmd(8'h20);
      rd("R10 unknown code ignored", 16'hA55A, 1'b1);
      cmd(8'h50);
      rd("R10 clear keeps array mode", 16'hA55A, 1'b1);
      cmd(8'h70);
      rd("R10 70 gives status", 16'h0080, 1'b1);
      cmd(8'hFF);
      op(1, 0, 0, 0, 0, 0);
      rd("R10 start forces status", 16'h0000, 1'b1);
      op(0, 1, 0, 0, 0, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_wsm;
      t_clear;
      t_susp;
      t_prot;
      t_snap;
      t_byte;
      t_mode;
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule